// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns one active-low external interrupt pin into a request line for an interrupt controller. The raw pin first passes through a flop synchroniser. It is then sampled only on clock cycles in which the machine-cycle strobe is high. A mode input picks how the sampled pin is read. In level mode a low sample asks for service and nothing is stored. In falling-edge mode a high-to-low step between two samples sets a sticky flag. That flag is the request, and it also marks the source as being in service.

The controller has two strobes for this source. It pulses an acknowledge strobe when it takes this source's vector, and a return strobe when that handler finishes. Between the two, the request is held low so the same source cannot re-enter. The return strobe also clears the edge flag, so the handler never has to clear it. Software can read the flag and can set or clear it with a write strobe, which lets it raise a test interrupt.

Top module: `xps_pin_cond`

## Requirements
- R1: During and straight after reset, `irq_req` and `flag` are 0, and the sampled pin level is taken as high (idle).
- R2: The pin reaches the sampler through SYNC_STAGES flops (default 2). The sampled level changes only at clock edges where `mc_en` is 1, so with `mc_en` held high a pin change reaches the sampled level 3 clocks later.
- R3: With `edge_mode` = 0 (level mode) and the source not in service, `irq_req` is 1 exactly while the sampled level is 0. Nothing is latched, so a pin that returns high before service leaves no request behind.
- R4: With `edge_mode` = 1, a falling edge sets `flag` at the same clock edge that samples the low level. A falling edge is an `mc_en` cycle where the previous sample is 1 and the synchronised pin is 0.
- R5: While `flag` is 1, further falling edges have no effect. An edge seen during that time is not stored, so `flag` stays 0 after it is cleared.
- R6: A `reti` pulse clears `flag` at the next clock edge, unless a software write happens in the same cycle.
- R7: A `flag_wr` pulse loads `flag_wdata` into `flag` at the next edge. It takes priority over `reti` and over a falling edge in the same cycle.
- R8: An `ack` pulse puts the source in service and `reti` takes it out. `reti` wins if both come in the same cycle. While in service, `irq_req` is 0.
- R9: With `edge_mode` = 1 and the source not in service, `irq_req` equals `flag`.
- R10: With `edge_mode` = 0, hardware never sets `flag`; only a software write can.
- R11: In level mode, if the sampled level is still 0 when `reti` arrives, `irq_req` returns to 1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n | input | 1 | Raw external interrupt pin, active low, asynchronous |
| mc_en | input | 1 | Machine-cycle strobe; the pin is sampled in cycles where it is 1 |
| edge_mode | input | 1 | Trigger type: 0 level, 1 falling edge |
| ack | input | 1 | Controller took this source's vector |
| reti | input | 1 | Return from this source's handler |
| flag_wr | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Value written to the flag |
| irq_req | output | 1 | Interrupt request to the controller |
| flag | output | 1 | Readable latched edge / in-service flag |

## Verification
The bound checker tests, on every cycle, the rules that hold over one clock step. It checks that the sample holds when the strobe is off and loads the synchronised pin when it is on. It checks that an edge sets the flag, that the flag stays set until cleared, that the return clears it, that a write wins over both, that acknowledge masks the request, and that level mode never sets the flag by hardware. Some behaviour only the bench scenarios can show. These are the three-clock delay from pin to request, that no request is left over when a low pulse ends too soon in level mode, that an edge seen during service is forgotten, and that the request comes back after a return while the pin is still low. The random phase compares both outputs against an independent cycle model while mode, strobe and pin all change.

// File: rtl/xps_pkg.sv
package xps_pkg;
   typedef enum logic {
      XPS_LEVEL = 1'b0,
      XPS_FALL  = 1'b1
   } xps_trig_e;

   localparam logic XPS_PIN_IDLE = 1'b1;
endpackage

// File: rtl/xps_sync.sv
module xps_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("xps_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain;

   generate
      for (genvar i = 0; i <= LAST; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[LAST];
endmodule

// File: rtl/xps_sampler.sv
module xps_sampler #(
   parameter logic IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic mc_en,
   output logic samp_q,
   output logic fall_evt,
   output logic level_act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     samp_q <= IDLE;
      else if (mc_en) samp_q <= pin_s;
   end

   // previous sample idle-high, new sample low, taken on a strobe
   assign fall_evt  = mc_en & (samp_q == IDLE) & (pin_s != IDLE);
   assign level_act = (samp_q != IDLE);
endmodule

// File: rtl/xps_flag.sv
module xps_flag
   import xps_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  xps_trig_e mode,
   input  logic      fall_evt,
   input  logic      reti,
   input  logic      wr,
   input  logic      wdata,
   output logic      flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     flag <= 1'b0;
      else if (wr)                                    flag <= wdata;
      else if (reti)                                  flag <= 1'b0;
      else if (mode == XPS_FALL && fall_evt && !flag) flag <= 1'b1;
   end
endmodule

// File: rtl/xps_service.sv
module xps_service (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   input  logic reti,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy <= 1'b0;
      else if (reti) busy <= 1'b0;
      else if (ack)  busy <= 1'b1;
   end
endmodule

// File: rtl/xps_pin_cond.sv
module xps_pin_cond
   import xps_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic mc_en,
   input  logic edge_mode,
   input  logic ack,
   input  logic reti,
   input  logic flag_wr,
   input  logic flag_wdata,
   output logic irq_req,
   output logic flag
);
   logic      pin_sync;
   logic      samp_q;
   logic      fall_evt;
   logic      level_act;
   logic      in_service;
   xps_trig_e mode;

   assign mode = xps_trig_e'(edge_mode);

   xps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(XPS_PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_sync)
   );

   xps_sampler #(.IDLE(XPS_PIN_IDLE)) u_samp (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_sync), .mc_en(mc_en),
      .samp_q(samp_q), .fall_evt(fall_evt), .level_act(level_act)
   );

   xps_flag u_flag (
      .clk(clk), .rst_n(rst_n), .mode(mode), .fall_evt(fall_evt),
      .reti(reti), .wr(flag_wr), .wdata(flag_wdata), .flag(flag)
   );

   xps_service u_svc (
      .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .busy(in_service)
   );

   always_comb begin
      irq_req = 1'b0;
      if (!in_service) begin
         if (mode == XPS_FALL) irq_req = flag;
         else                  irq_req = level_act;
      end
   end
endmodule

// File: rtl/xps_pin_cond_chk.sv
module xps_pin_cond_chk (
   input logic clk,
   input logic rst_n,
   input logic mc_en,
   input logic edge_mode,
   input logic ack,
   input logic reti,
   input logic flag_wr,
   input logic flag_wdata,
   input logic pin_s,
   input logic samp_q,
   input logic irq_req,
   input logic flag
);
   assert_hold_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mc_en |=> $stable(samp_q));

   assert_take_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mc_en |=> samp_q == $past(pin_s));

   assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && !flag_wr && !reti && mc_en && samp_q && !pin_s) |=> flag);

   assert_sticky_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_wr && !reti) |=> flag);

   assert_reti_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !flag_wr) |=> !flag);

   assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |=> flag == $past(flag_wdata));

   assert_ack_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !reti) |=> !irq_req);

   assert_level_noset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && !flag && !flag_wr) |=> !flag);
endmodule

bind xps_pin_cond xps_pin_cond_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .edge_mode(edge_mode),
   .ack(ack), .reti(reti), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
   .pin_s(pin_sync), .samp_q(samp_q), .irq_req(irq_req), .flag(flag)
);

// File: tb/xps_pin_cond_tb.sv
module xps_pin_cond_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_n = 1'b1, mc_en = 1'b1, edge_mode = 1'b0;
   logic ack = 1'b0, reti = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
   logic irq_req, flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   xps_pin_cond u_dut (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mc_en(mc_en),
      .edge_mode(edge_mode), .ack(ack), .reti(reti), .flag_wr(flag_wr),
      .flag_wdata(flag_wdata), .irq_req(irq_req), .flag(flag)
   );

   // reference model built from the requirements
   logic m_s1, m_s2, m_samp, m_flag, m_busy, p_wr, p_reti;
   logic m_fall;
   assign m_fall = mc_en & m_samp & ~m_s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 1'b1; m_s2 <= 1'b1; m_samp <= 1'b1;
         m_flag <= 1'b0; m_busy <= 1'b0; p_wr <= 1'b0; p_reti <= 1'b0;
      end else begin
         m_s1 <= pin_n;
         m_s2 <= m_s1;
         if (mc_en) m_samp <= m_s2;
         if (flag_wr)                       m_flag <= flag_wdata;
         else if (reti)                     m_flag <= 1'b0;
         else if (edge_mode && m_fall)      m_flag <= 1'b1;
         if (reti)     m_busy <= 1'b0;
         else if (ack) m_busy <= 1'b1;
         p_wr <= flag_wr;
         p_reti <= reti;
      end
   end

   function automatic logic exp_irq();
      if (m_busy) return 1'b0;
      return edge_mode ? m_flag : ~m_samp;
   endfunction

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(irq_req, exp_irq(), m_busy ? "R8 irq_req" : (edge_mode ? "R9 irq_req" : "R3 irq_req"));
         check(flag, m_flag, p_wr ? "R7 flag" : (p_reti ? "R6 flag" : "R4 flag"));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_in(input logic p, input logic m, input logic md,
                         input logic a, input logic r, input logic w, input logic wd);
      #1;
      pin_n = p; mc_en = m; edge_mode = md; ack = a; reti = r;
      flag_wr = w; flag_wdata = wd;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int unsigned r;
      r = $urandom(32'h5eed);
      tick(3);
      check(irq_req, 1'b0, "R1 reset irq");
      check(flag, 1'b0, "R1 reset flag");
      set_in(1, 1, 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      tick(2);
      check(irq_req, 1'b0, "R1 after reset");

      // level mode, latency and unlatched behaviour
      set_in(0, 1, 0, 0, 0, 0, 0);
      tick(2); check(irq_req, 1'b0, "R2 not yet sampled");
      tick(1); check(irq_req, 1'b1, "R3 low level requests");
      set_in(1, 1, 0, 0, 0, 0, 0);
      tick(3); check(irq_req, 1'b0, "R3 unlatched release");
      check(flag, 1'b0, "R10 level mode flag");

      // strobe gating
      set_in(0, 0, 0, 0, 0, 0, 0);
      tick(5); check(irq_req, 1'b0, "R2 no strobe no sample");
      set_in(0, 1, 0, 0, 0, 0, 0);
      tick(1); check(irq_req, 1'b1, "R2 strobe samples");
      check(flag, 1'b0, "R10 level low flag");

      // service in level mode
      set_in(0, 1, 0, 1, 0, 0, 0);
      tick(1); check(irq_req, 1'b0, "R8 ack masks");
      set_in(0, 1, 0, 0, 0, 0, 0);
      tick(3); check(irq_req, 1'b0, "R8 stays masked");
      set_in(0, 1, 0, 0, 1, 0, 0);
      tick(1); check(irq_req, 1'b1, "R11 re-request after return");
      set_in(1, 1, 0, 0, 0, 0, 0);
      tick(3);

      // edge mode
      set_in(1, 1, 1, 0, 0, 0, 0);
      tick(1);
      set_in(0, 1, 1, 0, 0, 0, 0);
      tick(2); check(flag, 1'b0, "R4 before edge sampled");
      tick(1); check(flag, 1'b1, "R4 edge sets flag");
      check(irq_req, 1'b1, "R9 edge request");
      set_in(1, 1, 1, 1, 0, 0, 0);
      tick(1); check(irq_req, 1'b0, "R8 ack masks edge");
      set_in(1, 1, 1, 0, 0, 0, 0);
      tick(3);
      set_in(0, 1, 1, 0, 0, 0, 0);
      tick(3); check(flag, 1'b1, "R5 flag held during edge");
      set_in(0, 1, 1, 0, 1, 0, 0);
      tick(1); check(flag, 1'b0, "R6 return clears");
      check(irq_req, 1'b0, "R9 cleared no request");
      set_in(0, 1, 1, 0, 0, 0, 0);
      tick(4); check(flag, 1'b0, "R5 ignored edge not stored");
      set_in(1, 1, 1, 0, 0, 0, 0);
      tick(3);

      // write precedence
      set_in(0, 1, 1, 0, 0, 0, 0);
      tick(2);
      set_in(0, 1, 1, 0, 0, 1, 0);
      tick(1); check(flag, 1'b0, "R7 write beats edge");
      set_in(0, 1, 1, 0, 1, 1, 1);
      tick(1); check(flag, 1'b1, "R7 write beats return");
      set_in(0, 1, 0, 0, 0, 1, 0);
      tick(1); check(flag, 1'b0, "R7 write clears");
      set_in(1, 1, 0, 0, 0, 0, 0);
      tick(3);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic p, m, md, a, rt, w, wd;
         p  = ($urandom % 8 == 0) ? ~pin_n : pin_n;
         m  = ($urandom % 3 == 0);
         md = ($urandom % 100 == 0) ? ~edge_mode : edge_mode;
         a  = ($urandom % 20 == 0);
         rt = ($urandom % 20 == 0);
         w  = ($urandom % 30 == 0);
         wd = $urandom % 2;
         set_in(p, m, md, a, rt, w, wd);
         tick(1);
      end
      finish_run();
   end
endmodule